// File: doc/BRIEF.md
# Multi-Cycle Reduced-Instruction Processor Core

This block is a small, non-pipelined processor core. It executes a reduced three-operand instruction set:

- register add, subtract and signed set-less-than;
- add-immediate;
- a conditional branch taken on inequality;
- an absolute jump, and a jump that also saves a return address;
- word load and word store;
- a cache-control instruction;
- halt.

Each instruction passes through fetch, decode and execute cycles. Loads and stores add a memory phase that lasts until the data port reports ready.

Instruction words come from a synchronous read port. The word addressed in one cycle is returned in the next. Data accesses use a request/ready handshake: the core holds the request, address, write enable and write data steady until ready is seen.

The cache-control instruction does not touch a cache inside the core. It raises one of three single-cycle pulses (disable, enable, flush) for a cache that sits outside the block. Once the core halts it stays halted, with its program counter frozen, until reset.

Top module: `mcore_top`

## Requirements
- R1: A synchronous active-low reset clears the program counter and all registers to zero and leaves halted low; the first fetch after reset is from address 0.
- R2: ADD writes rs+rt to rd, SUB writes rs−rt to rd, ADDI writes rs plus the sign-extended 16-bit immediate to rt, all modulo 2^32.
- R3: SLT writes 1 to rd when rs is less than rt as signed two's-complement values, otherwise 0.
- R4: Writes to register 0 are discarded; register 0 always reads as zero.
- R5: BNE loads the PC with PC+4 plus the sign-extended offset times 4 when rs differs from rt, and with PC+4 otherwise.
- R6: J loads the PC with the 26-bit target times 4. JAL does the same and also writes the old PC+4 into register 7.
- R7: LW and SW access address rs plus the sign-extended offset. The request, address, write enable and store data are held until the cycle in which ready is high. LW then writes the returned data to rt, and SW sends rt as write data.
- R8: CACHE with code 0 pulses cache_off, code 1 pulses cache_on and code 2 pulses cache_flush, each for exactly the execute cycle. Any other code pulses nothing. The code is the low 16 bits of the word.
- R9: HALT (opcode 11) and every undefined opcode assert halted from the cycle after execute. While halted, halted stays high, the fetch address does not change and no data request is made, until reset.
- R10: Instruction word layout is opcode [31:26], rs [25:21], rt [20:16], rd [15:11], immediate [15:0] and target [25:0]. Opcodes are ADD 1, ADDI 2, SUB 3, SLT 4, BNE 5, J 6, JAL 7, LW 8, SW 9, CACHE 10 and HALT 11. The PC is driven on imem_addr during a fetch cycle and the following decode cycle. Non-memory instructions take exactly three cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| imem_addr | output | 32 | Instruction byte address (the PC) |
| imem_rdata | input | 32 | Instruction word, one cycle after the address |
| dmem_req | output | 1 | Data access request |
| dmem_we | output | 1 | High for a store, low for a load |
| dmem_addr | output | 32 | Data byte address |
| dmem_wdata | output | 32 | Store data |
| dmem_rdata | input | 32 | Load data, valid with ready |
| dmem_ready | input | 1 | Data port completes the access this cycle |
| cache_off | output | 1 | One-cycle cache disable pulse |
| cache_on | output | 1 | One-cycle cache enable pulse |
| cache_flush | output | 1 | One-cycle cache flush pulse |
| halted | output | 1 | Core has stopped |

## Verification
The bench builds the core with its default 32 registers and with the link register at 7. This brings the full 5-bit register field into reach and lets the link write be told apart from the conventional register 31. The data port answers with latencies of zero, one and three wait cycles in turn, so that held requests and junk read data during wait cycles are both exercised. Two programs are run, separated by a reset. The second stores registers before writing any of them, which shows that reset clears the register file. It ends on an explicit halt, while the first ends on an undefined opcode after backward branches and jumps.

// File: rtl/mcore_pkg.sv
// Shared types for the multi-cycle core: opcode values, decoded instruction
// record, ALU operation and controller state. Assumes a fixed 32-bit word.
package mcore_pkg;

    localparam int XLEN = 32;

    localparam logic [5:0] OPC_ADD   = 6'd1;
    localparam logic [5:0] OPC_ADDI  = 6'd2;
    localparam logic [5:0] OPC_SUB   = 6'd3;
    localparam logic [5:0] OPC_SLT   = 6'd4;
    localparam logic [5:0] OPC_BNE   = 6'd5;
    localparam logic [5:0] OPC_J     = 6'd6;
    localparam logic [5:0] OPC_JAL   = 6'd7;
    localparam logic [5:0] OPC_LW    = 6'd8;
    localparam logic [5:0] OPC_SW    = 6'd9;
    localparam logic [5:0] OPC_CACHE = 6'd10;
    localparam logic [5:0] OPC_HALT  = 6'd11;

    typedef enum logic [3:0] {
        K_ADD, K_ADDI, K_SUB, K_SLT, K_BNE, K_J, K_JAL,
        K_LW, K_SW, K_CACHE, K_HALT
    } kind_e;

    typedef enum logic [1:0] {ALU_ADD, ALU_SUB, ALU_SLT} alu_op_e;

    typedef enum logic [2:0] {S_FETCH, S_DECODE, S_EXEC, S_MEM, S_HALT} state_e;

    // cache_sel order: {disable, enable, flush}
    typedef struct packed {
        kind_e            kind;
        logic [4:0]       rs;
        logic [4:0]       rt;
        logic [4:0]       rd;
        logic [XLEN-1:0]  imm;
        logic [25:0]      target;
        logic [2:0]       cache_sel;
    } dec_t;

endpackage

// File: rtl/mcore_decode.sv
// Instruction decoder: splits a 32-bit word into fields, sign-extends the
// immediate and classifies the opcode. Undefined opcodes decode as halt.
module mcore_decode
    import mcore_pkg::*;
(
    input  logic [31:0] instr,
    output dec_t        dec
);

    // Field extraction and opcode classification.
    always_comb begin
        dec.rs        = instr[25:21];
        dec.rt        = instr[20:16];
        dec.rd        = instr[15:11];
        dec.imm       = {{(XLEN-16){instr[15]}}, instr[15:0]};
        dec.target    = instr[25:0];
        dec.cache_sel = 3'b000;
        unique case (instr[31:26])
            OPC_ADD:   dec.kind = K_ADD;
            OPC_ADDI:  dec.kind = K_ADDI;
            OPC_SUB:   dec.kind = K_SUB;
            OPC_SLT:   dec.kind = K_SLT;
            OPC_BNE:   dec.kind = K_BNE;
            OPC_J:     dec.kind = K_J;
            OPC_JAL:   dec.kind = K_JAL;
            OPC_LW:    dec.kind = K_LW;
            OPC_SW:    dec.kind = K_SW;
            OPC_CACHE: dec.kind = K_CACHE;
            default:   dec.kind = K_HALT;
        endcase
        if (dec.kind == K_CACHE) begin
            unique case (instr[15:0])
                16'd0:   dec.cache_sel = 3'b100;
                16'd1:   dec.cache_sel = 3'b010;
                16'd2:   dec.cache_sel = 3'b001;
                default: dec.cache_sel = 3'b000;
            endcase
        end
    end

endmodule

// File: rtl/mcore_alu.sv
// Integer ALU: add, subtract, signed set-less-than, plus an equality flag
// on the raw operands. Purely combinational.
module mcore_alu
    import mcore_pkg::*;
#(
    parameter int W = XLEN
) (
    input  alu_op_e      op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] y,
    output logic         eq
);

    // Result selection by operation.
    always_comb begin
        unique case (op)
            ALU_SUB: y = a - b;
            ALU_SLT: y = ($signed(a) < $signed(b)) ? W'(1) : W'(0);
            default: y = a + b;
        endcase
    end

    // Operand equality for the conditional branch.
    assign eq = (a == b);

endmodule

// File: rtl/mcore_regfile.sv
// General register file: two combinational read ports, one synchronous write
// port, synchronous active-low clear. Entry 0 is never written.
module mcore_regfile #(
    parameter int NREG = 32,
    parameter int W    = 32,
    localparam int AW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] ra_a,
    input  logic [AW-1:0] ra_b,
    output logic [W-1:0]  rd_a,
    output logic [W-1:0]  rd_b,
    input  logic          we,
    input  logic [AW-1:0] wa,
    input  logic [W-1:0]  wd
);

    logic [W-1:0] mem [NREG];

    // Clear on reset, otherwise write any entry except 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) mem[i] <= '0;
        end else if (we && (wa != '0)) begin
            mem[wa] <= wd;
        end
    end

    // Read ports.
    assign rd_a = mem[ra_a];
    assign rd_b = mem[ra_b];

    assert_r0_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ra_a == '0) |-> (rd_a == '0));

endmodule

// File: rtl/mcore_top.sv
// Multi-cycle core top: fetch / decode / execute / memory / halt controller,
// program counter, instruction register and writeback. Assumes the instruction
// port returns data one cycle after the address and the data port may stall.
module mcore_top
    import mcore_pkg::*;
#(
    parameter int NREG     = 32,
    parameter int LINK_REG = 7
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [XLEN-1:0] imem_addr,
    input  logic [31:0]     imem_rdata,
    output logic            dmem_req,
    output logic            dmem_we,
    output logic [XLEN-1:0] dmem_addr,
    output logic [XLEN-1:0] dmem_wdata,
    input  logic [XLEN-1:0] dmem_rdata,
    input  logic            dmem_ready,
    output logic            cache_off,
    output logic            cache_on,
    output logic            cache_flush,
    output logic            halted
);

    localparam int AW = $clog2(NREG);
    localparam logic [AW-1:0] LINK_A = AW'(LINK_REG);

    state_e          state;
    logic [XLEN-1:0] pc;
    logic [31:0]     ir;
    dec_t            dec;
    logic [XLEN-1:0] rs_val, rt_val, alu_b, alu_y, pc_plus4, pc_next;
    logic            ops_eq;
    alu_op_e         alu_op;
    logic            rf_we;
    logic [AW-1:0]   rf_wa;
    logic [XLEN-1:0] rf_wd;
    logic            mem_done;

    mcore_decode u_dec (.instr(ir), .dec(dec));

    mcore_regfile #(.NREG(NREG), .W(XLEN)) u_rf (
        .clk(clk), .rst_n(rst_n),
        .ra_a(dec.rs[AW-1:0]), .ra_b(dec.rt[AW-1:0]),
        .rd_a(rs_val), .rd_b(rt_val),
        .we(rf_we), .wa(rf_wa), .wd(rf_wd)
    );

    mcore_alu #(.W(XLEN)) u_alu (
        .op(alu_op), .a(rs_val), .b(alu_b), .y(alu_y), .eq(ops_eq)
    );

    // ALU operation and second operand selection.
    always_comb begin
        unique case (dec.kind)
            K_SUB:   alu_op = ALU_SUB;
            K_SLT:   alu_op = ALU_SLT;
            default: alu_op = ALU_ADD;
        endcase
        alu_b = (dec.kind inside {K_ADDI, K_LW, K_SW}) ? dec.imm : rt_val;
    end

    // Next program counter for the execute cycle.
    always_comb begin
        pc_plus4 = pc + XLEN'(4);
        unique case (dec.kind)
            K_BNE:      pc_next = ops_eq ? pc_plus4 : pc_plus4 + {dec.imm[XLEN-3:0], 2'b00};
            K_J, K_JAL: pc_next = {{(XLEN-28){1'b0}}, dec.target, 2'b00};
            K_HALT:     pc_next = pc;
            default:    pc_next = pc_plus4;
        endcase
    end

    assign mem_done = (state == S_MEM) && dmem_ready;

    // Register writeback selection.
    always_comb begin
        rf_we = 1'b0;
        rf_wa = dec.rd[AW-1:0];
        rf_wd = alu_y;
        if (state == S_EXEC) begin
            unique case (dec.kind)
                K_ADD, K_SUB, K_SLT: rf_we = 1'b1;
                K_ADDI: begin rf_we = 1'b1; rf_wa = dec.rt[AW-1:0]; end
                K_JAL:  begin rf_we = 1'b1; rf_wa = LINK_A; rf_wd = pc_plus4; end
                default: rf_we = 1'b0;
            endcase
        end else if (mem_done && dec.kind == K_LW) begin
            rf_we = 1'b1;
            rf_wa = dec.rt[AW-1:0];
            rf_wd = dmem_rdata;
        end
    end

    // Controller state, program counter and instruction register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_FETCH;
            pc    <= '0;
            ir    <= '0;
        end else begin
            unique case (state)
                S_FETCH:  state <= S_DECODE;
                S_DECODE: begin ir <= imem_rdata; state <= S_EXEC; end
                S_EXEC: begin
                    if (dec.kind inside {K_LW, K_SW}) state <= S_MEM;
                    else if (dec.kind == K_HALT)      state <= S_HALT;
                    else begin pc <= pc_next; state <= S_FETCH; end
                end
                S_MEM: if (dmem_ready) begin pc <= pc_plus4; state <= S_FETCH; end
                default: state <= S_HALT;
            endcase
        end
    end

    // Port drive.
    assign imem_addr   = pc;
    assign dmem_req    = (state == S_MEM);
    assign dmem_we     = (state == S_MEM) && (dec.kind == K_SW);
    assign dmem_addr   = alu_y;
    assign dmem_wdata  = rt_val;
    assign {cache_off, cache_on, cache_flush} =
        (state == S_EXEC && dec.kind == K_CACHE) ? dec.cache_sel : 3'b000;
    assign halted      = (state == S_HALT);

    assert_halt_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> (halted && $stable(imem_addr)));
    assert_halt_noreq_R9: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> !dmem_req);
    assert_cache_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cache_off, cache_on, cache_flush}));
    assert_cache_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cache_off || cache_on || cache_flush) |=> !(cache_off || cache_on || cache_flush));
    assert_mem_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (dmem_req && !dmem_ready) |=>
            (dmem_req && $stable(dmem_addr) && $stable(dmem_we) && $stable(dmem_wdata)));
    assert_fetch_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_FETCH) |=> ((state == S_DECODE) && $stable(imem_addr)));

endmodule

// File: tb/mcore_top_tb.sv
`timescale 1ns/1ps
// Bench: behavioural instruction-level model stepped cycle by cycle and
// compared against the ports each clock.
module mcore_top_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] imem_addr, imem_rdata;
    logic        dmem_req, dmem_we, dmem_ready;
    logic [31:0] dmem_addr, dmem_wdata, dmem_rdata;
    logic        cache_off, cache_on, cache_flush, halted;

    always #2 clk = ~clk;

    mcore_top u_dut (
        .clk(clk), .rst_n(rst_n),
        .imem_addr(imem_addr), .imem_rdata(imem_rdata),
        .dmem_req(dmem_req), .dmem_we(dmem_we), .dmem_addr(dmem_addr),
        .dmem_wdata(dmem_wdata), .dmem_rdata(dmem_rdata), .dmem_ready(dmem_ready),
        .cache_off(cache_off), .cache_on(cache_on), .cache_flush(cache_flush),
        .halted(halted)
    );

    logic [31:0] imem [64];
    string       itag [64];
    int          dmem [int];
    logic [31:0] mregs [32];
    logic [31:0] mpc;
    int          lat_sel = 0;
    int          errors = 0, checks = 0;
    bit          done = 1'b0;

    always @(posedge clk) imem_rdata <= imem[imem_addr[7:2]];

    function automatic logic [31:0] enc_r(int op, int rd, int rs, int rt);
        return {6'(op), 5'(rs), 5'(rt), 5'(rd), 11'd0};
    endfunction
    function automatic logic [31:0] enc_i(int op, int rt, int rs, int imm);
        return {6'(op), 5'(rs), 5'(rt), 16'(imm)};
    endfunction
    function automatic logic [31:0] enc_j(int op, int tgt);
        return {6'(op), 26'(tgt)};
    endfunction

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic put(int idx, logic [31:0] w, string tag);
        imem[idx] = w;
        itag[idx] = tag;
    endtask

    task automatic clear_prog();
        for (int i = 0; i < 64; i++) begin imem[i] = 32'd0; itag[i] = "R9"; end
        dmem.delete();
    endtask

    task automatic model_reset();
        for (int i = 0; i < 32; i++) mregs[i] = 32'd0;
        mpc = 32'd0;
    endtask

    task automatic mwr(logic [4:0] r, logic [31:0] v);
        if (r != 5'd0) mregs[r] = v;
    endtask

    // Non-execute cycle with the core running: fetch address, no request.
    task automatic quiet_cycle(string req);
        chk(req, "imem_addr", imem_addr, mpc);
        chk("R9", "halted low", {31'd0, halted}, 32'd0);
        chk("R7", "no request", {31'd0, dmem_req}, 32'd0);
        chk("R8", "no cache pulse", {29'd0, cache_off, cache_on, cache_flush}, 32'd0);
        @(negedge clk);
    endtask

    task automatic run(int max_instr);
        string prev = "R1";
        for (int n = 0; n < max_instr; n++) begin
            logic [31:0] w = imem[mpc[7:2]];
            string tag = itag[mpc[7:2]];
            logic [5:0] opc = w[31:26];
            logic [4:0] rs = w[25:21], rt = w[20:16], rd = w[15:11];
            logic [31:0] imm = {{16{w[15]}}, w[15:0]};
            logic [2:0] cexp = 3'b000;
            quiet_cycle(prev);
            quiet_cycle("R10");
            if (opc == 6'd10)
                cexp = (w[15:0] == 16'd0) ? 3'b100 : (w[15:0] == 16'd1) ? 3'b010 :
                       (w[15:0] == 16'd2) ? 3'b001 : 3'b000;
            chk("R8", "cache pulse", {29'd0, cache_off, cache_on, cache_flush}, {29'd0, cexp});
            chk("R7", "no request in execute", {31'd0, dmem_req}, 32'd0);
            chk("R9", "halted low in execute", {31'd0, halted}, 32'd0);
            @(negedge clk);
            prev = tag;
            case (opc)
                6'd1: begin mwr(rd, mregs[rs] + mregs[rt]); mpc += 4; end
                6'd2: begin mwr(rt, mregs[rs] + imm); mpc += 4; end
                6'd3: begin mwr(rd, mregs[rs] - mregs[rt]); mpc += 4; end
                6'd4: begin mwr(rd, ($signed(mregs[rs]) < $signed(mregs[rt])) ? 32'd1 : 32'd0); mpc += 4; end
                6'd5: mpc = (mregs[rs] != mregs[rt]) ? mpc + 4 + (imm << 2) : mpc + 4;
                6'd6: mpc = {4'd0, w[25:0], 2'b00};
                6'd7: begin mwr(5'd7, mpc + 4); mpc = {4'd0, w[25:0], 2'b00}; end
                6'd8, 6'd9: begin
                    logic [31:0] a = mregs[rs] + imm;
                    int lat = (lat_sel % 3 == 2) ? 3 : lat_sel % 3;
                    logic [31:0] rv = dmem.exists(int'(a)) ? 32'(dmem[int'(a)]) : 32'd0;
                    lat_sel++;
                    for (int k = 0; k <= lat; k++) begin
                        chk("R7", "request held", {31'd0, dmem_req}, 32'd1);
                        chk("R7", "data address", dmem_addr, a);
                        chk("R7", "write enable", {31'd0, dmem_we}, {31'd0, opc == 6'd9});
                        if (opc == 6'd9) chk(tag, "store data", dmem_wdata, mregs[rt]);
                        dmem_ready = (k == lat);
                        dmem_rdata = (k == lat) ? rv : 32'hDEADBEEF;
                        @(negedge clk);
                    end
                    dmem_ready = 1'b0;
                    if (opc == 6'd9) dmem[int'(a)] = int'(mregs[rt]);
                    else mwr(rt, rv);
                    mpc += 4;
                end
                6'd10: mpc += 4;
                default: begin
                    for (int k = 0; k < 6; k++) begin
                        chk("R9", "halted held", {31'd0, halted}, 32'd1);
                        chk("R9", "pc frozen", imem_addr, mpc);
                        chk("R9", "no request halted", {31'd0, dmem_req}, 32'd0);
                        @(negedge clk);
                    end
                    return;
                end
            endcase
        end
        chk("R9", "program reached halt", 32'd0, 32'd1);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL R10 watchdog expired: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; dmem_ready = 1'b0; dmem_rdata = 32'd0;
        clear_prog();
        put(0,  enc_i(2, 1, 0, 5),       "R2");
        put(1,  enc_i(2, 2, 0, -3),      "R2");
        put(2,  enc_r(1, 3, 1, 2),       "R2");
        put(3,  enc_r(3, 4, 2, 1),       "R2");
        put(4,  enc_r(4, 5, 4, 1),       "R3");
        put(5,  enc_r(4, 6, 1, 4),       "R3");
        put(6,  enc_i(2, 0, 0, 9),       "R4");
        put(7,  enc_i(9, 0, 0, 0),       "R4");
        put(8,  enc_i(9, 3, 0, 4),       "R2");
        put(9,  enc_i(9, 4, 0, 8),       "R2");
        put(10, enc_i(9, 5, 1, 7),       "R3");
        put(11, enc_i(9, 6, 0, 16),      "R3");
        put(12, enc_i(8, 8, 0, 4),       "R7");
        put(13, enc_r(1, 9, 8, 8),       "R7");
        put(14, enc_i(9, 9, 0, 20),      "R7");
        put(15, enc_i(10, 0, 0, 1),      "R8");
        put(16, enc_i(10, 0, 0, 0),      "R8");
        put(17, enc_i(10, 0, 0, 2),      "R8");
        put(18, enc_i(10, 0, 0, 3),      "R8");
        put(19, enc_i(5, 2, 1, 1),       "R5");
        put(20, enc_i(2, 10, 0, 99),     "R5");
        put(21, enc_i(5, 1, 1, 5),       "R5");
        put(22, enc_j(7, 30),            "R6");
        put(23, enc_i(9, 7, 0, 24),      "R6");
        put(24, enc_i(9, 10, 0, 28),     "R5");
        put(25, enc_j(6, 40),            "R6");
        put(30, enc_i(2, 11, 0, -1),     "R2");
        put(31, enc_i(2, 12, 11, 1),     "R2");
        put(32, enc_r(4, 13, 11, 0),     "R3");
        put(33, enc_i(9, 12, 0, 32),     "R2");
        put(34, enc_i(9, 13, 0, 36),     "R3");
        put(35, enc_j(6, 23),            "R6");
        put(40, enc_i(5, 2, 1, -2),      "R5");
        put(39, 32'hFC00_0000,           "R9");
        repeat (3) @(negedge clk);
        chk("R1", "reset fetch address", imem_addr, 32'd0);
        chk("R1", "reset halted", {31'd0, halted}, 32'd0);
        chk("R1", "reset request", {31'd0, dmem_req}, 32'd0);
        rst_n = 1'b1;
        model_reset();
        run(200);

        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R1", "reset clears halted", {31'd0, halted}, 32'd0);
        chk("R1", "reset clears pc", imem_addr, 32'd0);
        clear_prog();
        put(0, enc_i(9, 3, 0, 0),  "R1");
        put(1, enc_i(9, 7, 0, 4),  "R1");
        put(2, enc_j(11, 0),       "R9");
        @(negedge clk);
        rst_n = 1'b1;
        model_reset();
        run(50);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule